// File: doc/BRIEF.md
# Streaming Two-Dimensional Window Convolver

This block filters raster video one pixel per clock. Recent lines are held in on-chip line stores. Each accepted pixel forms a rectangular neighbourhood with pixels to its left on the same line and with the same columns on up to seven earlier lines. That neighbourhood is multiplied by a bank of sixty-four signed coefficients and summed to full precision. A host-style register port loads the coefficients, the window shape, the pixel width, the line length and the sync delay. Every value written can be read back.

A line-sync input marks the first pixel of each line and resets the column count. The column count wraps at the programmed line length, and the line stores are indexed by it. A delayed copy of line-sync is output, and its delay is programmable so that it lines up with the filtered data. The result latency is fixed for each shape and pixel width. To build a smaller window, load zeros into the coefficients that are not needed; this does not change the latency.

Top module: `conv2d_window`

## Requirements
- R1: A write takes place on a clock edge when `host_cs`, `host_stb` and `host_wr` are all high. The register map is: 0x00 is the mode register, 0x01 is the sync-delay select (bits 5:0), 0x02 and 0x03 are the low and high bytes of the 16-bit line length, and 0x40+i is coefficient Ci. `host_rdata` always shows the last value written to `host_addr`. Addresses 0x04 to 0x3F hold nothing and read as zero.
- R2: Mode bits 1:0 select the window shape: 0 is 4 wide by 4 tall, 1 is 8 wide by 4 tall, and 2 or 3 is 8 by 8. With wide pixels selected, codes 2 and 3 behave as 8 wide by 4 tall.
- R3: Horizontally, the oldest pixel of a row in the window (its leftmost) is multiplied by the coefficient with the lowest index of that row. The newest pixel takes the highest index.
- R4: The rows are inverted. The current line is the bottom row and uses C0 up to C(W-1), where W is the window width. The line k lines back uses C(k*W) up to C(k*W+W-1).
- R5: A result appears on `res_data` with `res_valid` high exactly L cycles after its pixel was presented with `pix_en`. For narrow pixels L is 34 for 4x4, 30 for 8x4 and 26 for 8x8. For wide pixels L is 28 for 4x4 and 26 for 8x4.
- R6: Mode bit 2 set means 16-bit unsigned pixels. Mode bit 2 clear means only `pix_in[7:0]` is used, and the upper byte has no effect on any result.
- R7: The sum is signed and at full precision. It stays exact for 64 products of full-scale pixels and coefficients of -128 or +127.
- R8: `sync_out` repeats `line_sync` delayed by 29+S cycles, where S is the sync-delay select from 0 to 63. This gives 29 to 92 cycles.
- R9: A `line_sync` cycle makes its pixel (if any) column 0. Each accepted pixel advances the column. The column returns to 0 after the column equal to the line length minus one.
- R10: When mode bit 3 is set, pixels arriving after the last column of a line (before the next `line_sync`) do not write the line stores. Their earlier-line rows read as zero.
- R11: After reset, all registers, line stores and window contents are zero, and `res_valid` and `sync_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Register port select |
| host_stb | input | 1 | Register access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| pix_en | input | 1 | A pixel is present on `pix_in` |
| pix_in | input | 16 | Pixel value, unsigned |
| line_sync | input | 1 | Start of line |
| sync_out | output | 1 | Delayed line sync |
| res_valid | output | 1 | `res_data` holds a result |
| res_data | output | 31 | Signed full-precision sum |

## Verification
Each pixel is due as a result exactly L cycles after it is driven, with L taken from the R5 table for the current mode. Each line-sync pulse is due on `sync_out` 29+S cycles after it is driven. The driver records the due cycle together with the expected sum, and the monitor compares both the arrival cycle and the value on the falling edge. A result that arrives early, arrives late or is missing is therefore caught in the same way as a wrong sum. The bench lets the pipeline drain before it changes the mode or the delay, so that each expected latency stays unambiguous.

// File: rtl/conv2d_pkg.sv
// Shared constants, mode encoding and per-mode geometry and latency.
// Assumes at most 8x8 taps and 64 coefficients.
package conv2d_pkg;
    localparam int unsigned WIN_MAX = 8;
    localparam int unsigned N_COEF  = 64;
    localparam int unsigned COEF_W  = 8;
    localparam int unsigned PPL_W   = 16;
    localparam int unsigned LAT_MAX = 34;

    typedef enum logic [1:0] {
        SHP_4X4  = 2'd0,
        SHP_8X4  = 2'd1,
        SHP_8X8  = 2'd2,
        SHP_8X8B = 2'd3
    } shape_e;

    typedef struct packed {
        logic   inhibit;
        logic   wide;
        shape_e shape;
    } mode_t;

    function automatic int unsigned win_cols(input shape_e s);
        return (s == SHP_4X4) ? 4 : 8;
    endfunction

    function automatic int unsigned win_rows(input shape_e s, input logic wide);
        return (s == SHP_4X4 || s == SHP_8X4 || wide) ? 4 : 8;
    endfunction

    function automatic int unsigned latency(input shape_e s, input logic wide);
        if (wide) return (s == SHP_4X4) ? 28 : 26;
        case (s)
            SHP_4X4: return 34;
            SHP_8X4: return 30;
            default: return 26;
        endcase
    endfunction
endpackage

// File: rtl/conv2d_regs.sv
// Host register file: mode, sync delay, line length, coefficient bank.
// Assumes the coefficient block starts at an address aligned to N_COEF.
module conv2d_regs
    import conv2d_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned SEL_W     = 6,
    parameter int unsigned COEF_BASE = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cs,
    input  logic                             stb,
    input  logic                             wr,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [7:0]                       wdata,
    output logic [7:0]                       rdata,
    output mode_t                            mode_o,
    output logic [SEL_W-1:0]                 sdly_o,
    output logic [PPL_W-1:0]                 ppl_o,
    output logic [N_COEF-1:0][COEF_W-1:0]    coef_o
);
    localparam int unsigned CI_W = $clog2(N_COEF);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SDLY = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CB   = ADDR_W'(COEF_BASE);

    logic              we;
    logic              is_coef;
    logic [CI_W-1:0]   cidx;

    assign we      = cs && stb && wr;
    assign is_coef = (addr >= A_CB);
    assign cidx    = CI_W'(addr - A_CB);

    // Register writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= '0;
            sdly_o <= '0;
            ppl_o  <= '0;
            coef_o <= '0;
        end else if (we) begin
            if (is_coef)             coef_o[cidx] <= wdata;
            else if (addr == A_MODE) mode_o <= mode_t'(wdata[$bits(mode_t)-1:0]);
            else if (addr == A_SDLY) sdly_o <= wdata[SEL_W-1:0];
            else if (addr == A_PLO)  ppl_o[7:0] <= wdata;
            else if (addr == A_PHI)  ppl_o[PPL_W-1:8] <= wdata[PPL_W-9:0];
        end
    end

    // Read mux; unmapped addresses give zero.
    always_comb begin
        rdata = '0;
        if (is_coef)             rdata = coef_o[cidx];
        else if (addr == A_MODE) rdata = 8'(mode_o);
        else if (addr == A_SDLY) rdata = 8'(sdly_o);
        else if (addr == A_PLO)  rdata = ppl_o[7:0];
        else if (addr == A_PHI)  rdata = ppl_o[PPL_W-1:8];
    end
endmodule

// File: rtl/conv2d_linebuf.sv
// Column counter, line stores and the 8x8 tap window.
// Assumes the programmed line length does not exceed MAX_LINE.
// win[r][a]: row r lines back, a clocks old (a=0 newest).
module conv2d_linebuf
    import conv2d_pkg::*;
#(
    parameter int unsigned PIX_W    = 16,
    parameter int unsigned MAX_LINE = 64
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         pix_en,
    input  logic [PIX_W-1:0]                             pix_in,
    input  logic                                         line_sync,
    input  logic                                         wide,
    input  logic                                         inhibit,
    input  logic [PPL_W-1:0]                             ppl,
    output logic [WIN_MAX-1:0][WIN_MAX-1:0][PIX_W-1:0]   win,
    output logic                                         win_vld
);
    localparam int unsigned AW      = $clog2(MAX_LINE);
    localparam int unsigned N_STORE = WIN_MAX - 1;

    logic [PIX_W-1:0]               store_q [N_STORE][MAX_LINE];
    logic [PPL_W-1:0]               col_q, col_eff, col_nxt;
    logic [AW-1:0]                  idx;
    logic                           active, wr_en;
    logic [PIX_W-1:0]               pix_m;
    logic [WIN_MAX-1:0][PIX_W-1:0]  rows;

    assign col_eff = line_sync ? '0 : col_q;
    assign idx     = col_eff[AW-1:0];
    assign active  = (col_eff < ppl);
    assign wr_en   = pix_en && (active || !inhibit);
    assign pix_m   = wide ? pix_in : {{(PIX_W-8){1'b0}}, pix_in[7:0]};

    // Next column: wrap at line end, or park there while inhibited.
    always_comb begin
        if ({1'b0, col_eff} + 17'd1 >= {1'b0, ppl}) col_nxt = inhibit ? ppl : '0;
        else                                      col_nxt = col_eff + 1'b1;
    end

    // Vertical taps: current pixel plus the stored earlier lines.
    always_comb begin
        rows[0] = pix_m;
        for (int k = 1; k < WIN_MAX; k++) rows[k] = active ? store_q[k-1][idx] : '0;
    end

    // Column tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)      col_q <= '0;
        else if (pix_en) col_q <= col_nxt;
        else             col_q <= col_eff;
    end

    // Line stores: each column shifts one line deeper per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_STORE; k++)
                for (int i = 0; i < MAX_LINE; i++) store_q[k][i] <= '0;
        end else if (wr_en) begin
            store_q[0][idx] <= pix_m;
            for (int k = 1; k < N_STORE; k++) store_q[k][idx] <= store_q[k-1][idx];
        end
    end

    // Horizontal window shift and accept flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win     <= '0;
            win_vld <= 1'b0;
        end else begin
            win_vld <= pix_en;
            if (pix_en)
                for (int r = 0; r < WIN_MAX; r++) win[r] <= {win[r][WIN_MAX-2:0], rows[r]};
        end
    end
endmodule

// File: rtl/conv2d_mac.sv
// Weighted sum over the selected window, then a delay line whose
// tap gives the fixed latency of the current mode.
// Assumes win_vld and win refer to the same pixel.
module conv2d_mac
    import conv2d_pkg::*;
#(
    parameter int unsigned PIX_W = 16,
    parameter int unsigned ACC_W = PIX_W + 1 + COEF_W + $clog2(N_COEF)
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [WIN_MAX-1:0][WIN_MAX-1:0][PIX_W-1:0]   win,
    input  logic                                         win_vld,
    input  logic [N_COEF-1:0][COEF_W-1:0]                coef,
    input  shape_e                                       shape,
    input  logic                                         wide,
    output logic                                         res_valid,
    output logic [ACC_W-1:0]                             res_data
);
    localparam int unsigned DEPTH = LAT_MAX - 1;

    logic [ACC_W-1:0]   acc;
    logic [ACC_W-1:0]   dat_q [DEPTH];
    logic [DEPTH-1:0]   vld_q;
    int unsigned        n_cols, n_rows, tap;

    assign n_cols = win_cols(shape);
    assign n_rows = win_rows(shape, wide);
    assign tap    = latency(shape, wide) - 2;

    // Sum of coefficient times pixel; leftmost (oldest) takes the row's lowest index.
    always_comb begin
        acc = '0;
        for (int r = 0; r < WIN_MAX; r++)
            for (int x = 0; x < WIN_MAX; x++)
                if (r < n_rows && x < n_cols)
                    acc = acc + ($signed({{(ACC_W-COEF_W){coef[r*n_cols+x][COEF_W-1]}}, coef[r*n_cols+x]})
                               * $signed({{(ACC_W-PIX_W){1'b0}}, win[r][n_cols-1-x]}));
    end

    // Latency delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
        end else begin
            vld_q    <= {vld_q[DEPTH-2:0], win_vld};
            dat_q[0] <= acc;
            for (int i = 1; i < DEPTH; i++) dat_q[i] <= dat_q[i-1];
        end
    end

    assign res_valid = vld_q[tap];
    assign res_data  = dat_q[tap];
endmodule

// File: rtl/conv2d_syncdly.sv
// Programmable delay of the line-sync pulse, DLY_MIN .. DLY_MIN+2^SEL_W-1.
// Assumes the select is not changed while pulses are in flight.
module conv2d_syncdly #(
    parameter int unsigned SEL_W   = 6,
    parameter int unsigned DLY_MIN = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [SEL_W-1:0] sel,
    output logic             sync_out
);
    localparam int unsigned DEPTH = DLY_MIN + (1 << SEL_W) - 1;

    logic [DEPTH-1:0] sr_q;

    // Shift the sync history every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[DEPTH-2:0], sync_in};
    end

    assign sync_out = sr_q[DLY_MIN - 1 + sel];
endmodule

// File: rtl/conv2d_window.sv
// Top: register port, line buffer, multiply-accumulate and sync delay.
// Assumes one pixel per clock at most and line length <= MAX_LINE.
module conv2d_window
    import conv2d_pkg::*;
#(
    parameter int unsigned PIX_W    = 16,
    parameter int unsigned MAX_LINE = 64,
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned SEL_W    = 6,
    parameter int unsigned DLY_MIN  = 29
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             host_cs,
    input  logic                                             host_stb,
    input  logic                                             host_wr,
    input  logic [ADDR_W-1:0]                                host_addr,
    input  logic [7:0]                                       host_wdata,
    output logic [7:0]                                       host_rdata,
    input  logic                                             pix_en,
    input  logic [PIX_W-1:0]                                 pix_in,
    input  logic                                             line_sync,
    output logic                                             sync_out,
    output logic                                             res_valid,
    output logic [PIX_W+COEF_W+$clog2(N_COEF):0]             res_data
);
    localparam int unsigned ACC_W = PIX_W + 1 + COEF_W + $clog2(N_COEF);

    mode_t                           mode;
    logic [SEL_W-1:0]                sdly;
    logic [PPL_W-1:0]                ppl;
    logic [N_COEF-1:0][COEF_W-1:0]   coef;
    logic [WIN_MAX-1:0][WIN_MAX-1:0][PIX_W-1:0] win;
    logic                            win_vld;

    conv2d_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .COEF_BASE(1 << (ADDR_W-1))) u_regs (
        .clk(clk), .rst_n(rst_n), .cs(host_cs), .stb(host_stb), .wr(host_wr),
        .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
        .mode_o(mode), .sdly_o(sdly), .ppl_o(ppl), .coef_o(coef)
    );

    conv2d_linebuf #(.PIX_W(PIX_W), .MAX_LINE(MAX_LINE)) u_lbuf (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_in(pix_in),
        .line_sync(line_sync), .wide(mode.wide), .inhibit(mode.inhibit),
        .ppl(ppl), .win(win), .win_vld(win_vld)
    );

    conv2d_mac #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .win(win), .win_vld(win_vld), .coef(coef),
        .shape(mode.shape), .wide(mode.wide),
        .res_valid(res_valid), .res_data(res_data)
    );

    conv2d_syncdly #(.SEL_W(SEL_W), .DLY_MIN(DLY_MIN)) u_sdly (
        .clk(clk), .rst_n(rst_n), .sync_in(line_sync), .sel(sdly), .sync_out(sync_out)
    );
endmodule

// File: rtl/conv2d_window_chk.sv
// Port-level checks for conv2d_window, attached by bind.
module conv2d_window_chk #(
    parameter int unsigned ADDR_W  = 7,
    parameter int unsigned LAT_LIM = 34,
    parameter int unsigned SYN_LIM = 92
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cs,
    input logic              host_stb,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic              pix_en,
    input logic              line_sync,
    input logic              sync_out,
    input logic              res_valid
);
    logic [7:0] idle_q, quiet_q;

    // Count consecutive cycles without pixels and without line sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q  <= '0;
            quiet_q <= '0;
        end else begin
            idle_q  <= pix_en ? '0 : ((idle_q < 8'(LAT_LIM)) ? idle_q + 1'b1 : idle_q);
            quiet_q <= line_sync ? '0 : ((quiet_q < 8'(SYN_LIM)) ? quiet_q + 1'b1 : quiet_q);
        end
    end

    // R1: a coefficient write is visible on the read port next cycle
    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_stb && host_wr && host_addr[ADDR_W-1])
        |=> ((host_addr != $past(host_addr)) || (host_rdata == $past(host_wdata))));

    // R1: unmapped addresses read zero
    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr >= ADDR_W'(4) && !host_addr[ADDR_W-1]) |-> (host_rdata == 8'h00));

    // R5: no result without a pixel inside the longest latency window
    a_r5_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q >= 8'(LAT_LIM)) |-> !res_valid);

    // R8: no delayed sync without a sync inside the longest delay
    a_r8_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q >= 8'(SYN_LIM)) |-> !sync_out);
endmodule

bind conv2d_window conv2d_window_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_stb(host_stb),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .pix_en(pix_en), .line_sync(line_sync),
    .sync_out(sync_out), .res_valid(res_valid)
);

// File: tb/conv2d_window_bench.sv
// Scoreboard bench: drive tasks push due cycle and value, a monitor compares.
module conv2d_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 0, host_stb = 0, host_wr = 0;
    logic [6:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        pix_en = 0, line_sync = 0;
    logic [15:0] pix_in = '0;
    logic        sync_out, res_valid;
    logic [30:0] res_data;

    conv2d_window u_conv2d_window (.*);

    always #10 clk = ~clk;

    typedef struct { int due; longint val; string tag; } item_t;
    item_t exp_q[$];
    int    sync_q[$];
    int    cyc = 0, checks = 0, errors = 0;

    // Reference state
    longint bstore [7][64];
    longint bwin [8][8];
    int     bc [64];
    int     bcol = 0, bppl = 0, bsd = 0, bshape = 0;
    bit     bwide = 0, binh = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int f_cols(int s); return (s == 0) ? 4 : 8; endfunction
    function automatic int f_rows(int s, bit w); return (s <= 1 || w) ? 4 : 8; endfunction
    function automatic int f_lat(int s, bit w);
        if (w) return (s == 0) ? 28 : 26;
        return (s == 0) ? 34 : (s == 1) ? 30 : 26;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
        host_cs = 1; host_stb = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 0; host_stb = 0; host_wr = 0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [7:0] e, input string tag);
        host_cs = 1; host_stb = 1; host_wr = 0; host_addr = a;
        #2;
        check(host_rdata == e, tag, host_rdata, e);
        @(negedge clk);
        host_cs = 0; host_stb = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input int s, input bit w, input bit inh);
        bshape = s; bwide = w; binh = inh;
        wr_reg(7'h00, {4'b0, inh, w, 2'(s)});
    endtask

    task automatic load_coefs(input int kind);
        for (int i = 0; i < 64; i++) begin
            case (kind)
                0: bc[i] = ((i * 37 + 11) % 256) - 128;
                1: bc[i] = -128;
                2: bc[i] = 127;
                default: bc[i] = (i == kind - 3) ? 1 : 0;
            endcase
            wr_reg(7'h40 + 7'(i), 8'(bc[i]));
        end
    endtask

    // Drive one pixel; model its result from the requirements.
    task automatic drive_pix(input logic [15:0] p, input bit s, input string tag);
        longint pm, rowv[8], sum;
        int ce, idx, w, h;
        bit act;
        item_t it;
        pix_en = 1; pix_in = p; line_sync = s;
        pm  = bwide ? longint'(p) : longint'(p[7:0]);       // R6
        ce  = s ? 0 : bcol;                                  // R9
        act = (ce < bppl);
        idx = ce % 64;
        rowv[0] = pm;
        for (int k = 1; k < 8; k++) rowv[k] = act ? bstore[k-1][idx] : 0;   // R10
        if (act || !binh) begin
            for (int k = 6; k >= 1; k--) bstore[k][idx] = bstore[k-1][idx];
            bstore[0][idx] = pm;
        end
        for (int r = 0; r < 8; r++) begin
            for (int a = 7; a >= 1; a--) bwin[r][a] = bwin[r][a-1];
            bwin[r][0] = rowv[r];
        end
        bcol = (ce + 1 >= bppl) ? (binh ? bppl : 0) : ce + 1;
        w = f_cols(bshape); h = f_rows(bshape, bwide);       // R2
        sum = 0;
        for (int r = 0; r < h; r++)                          // R4 rows inverted
            for (int x = 0; x < w; x++)                      // R3 oldest is leftmost
                sum += longint'(bc[r*w + x]) * bwin[r][w-1-x];
        it.due = cyc + f_lat(bshape, bwide); it.val = sum; it.tag = tag;
        exp_q.push_back(it);
        if (s) sync_q.push_back(cyc + bsd);
        @(negedge clk);
        pix_en = 0; line_sync = 0;
    endtask

    task automatic stream(input int nlines, input bit hi_noise, input string tag);
        for (int l = 0; l < nlines; l++)
            for (int c = 0; c < bppl; c++) begin
                logic [15:0] v;
                v = 16'($urandom);
                if (!bwide && !hi_noise) v[15:8] = 8'h00;
                drive_pix(v, c == 0, tag);
            end
        idle(40);
    endtask

    task automatic sync_pulse(input int sel);
        bsd = 29 + sel;
        wr_reg(7'h01, 8'(sel));
        line_sync = 1;
        sync_q.push_back(cyc + bsd);
        bcol = 0;
        @(negedge clk);
        line_sync = 0;
        idle(100);
    endtask

    // Monitor: result and delayed-sync scoreboards.
    initial begin
        forever begin
            @(negedge clk);
            if (res_valid) begin
                if (exp_q.size() == 0) check(0, "R5 unexpected result", cyc, -1);
                else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(cyc == it.due, {it.tag, " R5 cycle"}, cyc, it.due);
                    check(longint'($signed(res_data)) == it.val, {it.tag, " value"},
                          longint'($signed(res_data)), it.val);
                end
            end
            if (sync_out) begin
                if (sync_q.size() == 0) check(0, "R8 unexpected sync_out", cyc, -1);
                else begin
                    int d;
                    d = sync_q.pop_front();
                    check(cyc == d, "R8 sync delay", cyc, d);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        check(0, "watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) for (int i = 0; i < 64; i++) bstore[k][i] = 0;
        for (int r = 0; r < 8; r++) for (int a = 0; a < 8; a++) bwin[r][a] = 0;
        for (int i = 0; i < 64; i++) bc[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check(res_valid == 0, "R11 res_valid", res_valid, 0);
        check(sync_out == 0, "R11 sync_out", sync_out, 0);
        rd_chk(7'h00, 8'h00, "R11 mode");
        rd_chk(7'h03, 8'h00, "R11 ppl hi");
        rd_chk(7'h7F, 8'h00, "R11 coef 63");

        // R1: map and readback
        wr_reg(7'h01, 8'd5);  bsd = 34;
        wr_reg(7'h02, 8'd8);  wr_reg(7'h03, 8'd0); bppl = 8;
        wr_reg(7'h45, 8'hA5);
        wr_reg(7'h10, 8'h5A);
        rd_chk(7'h01, 8'd5, "R1 sync sel");
        rd_chk(7'h02, 8'd8, "R1 ppl lo");
        rd_chk(7'h45, 8'hA5, "R1 coef");
        rd_chk(7'h10, 8'h00, "R1 unused");
        host_cs = 1; host_stb = 1; host_wr = 1; host_addr = 7'h46; host_wdata = 8'h3C;
        @(negedge clk);
        host_cs = 0;  // R1: chip select low blocks the write
        host_wdata = 8'h77;
        @(negedge clk);
        host_stb = 0; host_wr = 0;
        rd_chk(7'h46, 8'h3C, "R1 write needs cs");

        // R2 R3 R4 R5: all shapes with distinct coefficients
        load_coefs(0);
        set_mode(0, 0, 0); stream(6, 1, "R2 R3 R4 R6 narrow 4x4");
        set_mode(1, 0, 0); stream(6, 0, "R2 narrow 8x4");
        set_mode(2, 0, 0); stream(9, 0, "R2 narrow 8x8");
        set_mode(3, 0, 0); stream(9, 1, "R2 narrow code3");
        set_mode(0, 1, 0); stream(6, 0, "R6 wide 4x4");
        set_mode(1, 1, 0); stream(6, 0, "R6 wide 8x4");
        set_mode(2, 1, 0); stream(6, 0, "R2 wide code2 as 8x4");

        // R3 R4: single-hot coefficients locate taps
        load_coefs(3 + 1);  set_mode(1, 0, 0); stream(5, 0, "R3 tap C1");
        load_coefs(3 + 8);  stream(5, 0, "R4 tap C8");
        load_coefs(3 + 63); set_mode(2, 0, 0); stream(9, 0, "R4 tap C63");

        // R7: full-scale sums
        load_coefs(1); set_mode(2, 0, 0);
        for (int i = 0; i < 72; i++) drive_pix(16'hFFFF, (i % 8) == 0, "R7 neg narrow");
        idle(40);
        set_mode(1, 1, 0);
        for (int i = 0; i < 40; i++) drive_pix(16'hFFFF, (i % 8) == 0, "R7 neg wide");
        idle(40);
        load_coefs(2);
        for (int i = 0; i < 40; i++) drive_pix(16'hFFFF, (i % 8) == 0, "R7 pos wide");
        idle(40);

        // R9: mid-line resync and wrap without sync, other length
        load_coefs(0); set_mode(1, 0, 0);
        wr_reg(7'h02, 8'd13); bppl = 13;
        for (int i = 0; i < 3; i++) drive_pix(16'(i * 9 + 4), i == 0, "R9 partial");
        for (int i = 0; i < 52; i++) drive_pix(16'($urandom), i == 0, "R9 wrap");
        idle(40);

        // R10: inhibited writes past line end
        set_mode(0, 0, 1);
        for (int l = 0; l < 5; l++) begin
            for (int c = 0; c < 13; c++) drive_pix(16'($urandom), c == 0, "R10 active");
            for (int c = 0; c < 4; c++) drive_pix(16'hFF, 0, "R10 blank");
        end
        idle(40);

        // R8: sync delay extremes
        sync_pulse(0);
        sync_pulse(63);
        sync_pulse(17);

        check(exp_q.size() == 0, "R5 results missing", exp_q.size(), 0);
        check(sync_q.size() == 0, "R8 syncs missing", sync_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule